// File: doc/BRIEF.md
# Interruptible Iterative Divider

A sequential divider that turns a dividend and a divisor into a 16-bit quotient and a 16-bit remainder. It handles a 32-bit or a 16-bit dividend over a 16-bit divisor, in integer or Q15 fractional form, with signed or unsigned operands. The work is split into 19 steps. Each step runs on one clock edge with the `step` strobe high, as if a divide instruction were re-issued once per pass of a repeat loop.

All partial state is held in registers inside the block. This covers the step index, the partial remainder, the quotient/dividend shift register, the divisor magnitude and the result signs. When `step` is low nothing moves, so a divide can be suspended between any two steps and resumed later with an identical result.

The first step captures the operands and the mode, forms magnitudes and notes the result signs. The next 17 steps each resolve one quotient bit by shift-compare-subtract. The last step applies the signs, checks the range and writes the result registers.

Top module: `stepdiv`

## Requirements
- R1: A step taken at stage 0 captures `dividend`, `divisor`, `is_long`, `is_signed` and `is_frac`. Changes on those inputs during the remaining 18 steps have no effect on the result.
- R2: Each step advances `stage` by one, from 0 through 18 and back to 0. `busy` is high while `stage` is not 0. `done` goes high after the step taken at stage 18.
- R3: While `step` is low, `stage`, `quotient`, `remainder`, `done`, `ovf` and `dz` hold. A divide with idle gaps between steps gives the same outputs as one without gaps.
- R4: Signed integer mode (`is_signed`=1, `is_frac`=0) gives a quotient truncated toward zero, in two's complement. The remainder takes the sign of the dividend and satisfies dividend = quotient*divisor + remainder. With `is_long`=1 the full 32-bit dividend is used. With `is_long`=0 only `dividend[15:0]` is used, sign-extended.
- R5: Unsigned integer mode (`is_signed`=0, `is_frac`=0) treats the operands as unsigned. With `is_long`=0 only `dividend[15:0]` is used, zero-extended.
- R6: Fractional mode (`is_frac`=1) takes `dividend[15:0]` and `divisor` as Q15 values and ignores `is_long`. The quotient is trunc(a*2^15/b). The remainder is a*2^15 - quotient*b, with the sign of a. `is_signed` selects two's complement or unsigned operands.
- R7: In fractional mode, `ovf` is set when |a| >= |b|.
- R8: In integer mode, `ovf` is set when the exact quotient lies outside [-32768, 32767] (signed) or above 65535 (unsigned).
- R9: A zero divisor sets `dz` and clears `ovf`. Whenever `dz` or `ovf` is set by the last step, `quotient` and `remainder` keep their previous values.
- R10: `ovf` and `dz` change only on the last step. `done` clears on the first step of a new divide. Reset sets every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Perform one divide step on this edge |
| is_long | input | 1 | 32-bit dividend when 1, 16-bit when 0 (integer only) |
| is_signed | input | 1 | Two's complement operands |
| is_frac | input | 1 | Q15 fractional divide |
| dividend | input | 32 | Dividend, sampled on the first step |
| divisor | input | 16 | Divisor, sampled on the first step |
| quotient | output | 16 | Quotient register |
| remainder | output | 16 | Remainder register |
| stage | output | 5 | Step index, 0 = idle / next step loads |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | Last divide has completed |
| ovf | output | 1 | Last divide overflowed |
| dz | output | 1 | Last divide had a zero divisor |

## Verification
On the final step, the range and zero-divisor flags rise on the same edge that would otherwise write the result registers. The write must be suppressed on exactly that edge while the flags update. The bench provokes this with overflowing integer divides, |a| >= |b| fractional divides and zero divisors, placed between valid divides. It judges the outcome by comparing `quotient` and `remainder` against the last good values the bench itself recorded. A second collision, suspension on the stage before the last step, is provoked with random idle gaps. It is judged by `stage` holding through the gap and by the final result matching the arithmetic expectation.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

  // operand interpretation captured on the load step
  typedef struct packed {
    logic lng;   // 32-bit dividend (integer forms only)
    logic sgn;   // two's complement operands
    logic frac;  // Q15 fractional form
  } dmode_t;

  // what a strobed step does, decoded from the step index
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_ITER = 2'd1,
    PH_FIX  = 2'd2
  } phase_t;

endpackage

// File: rtl/stepdiv_prep.sv
module stepdiv_prep
  import stepdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  dmode_t           mode,
  input  logic [2*W-1:0]   dividend,
  input  logic [W-1:0]     divisor,
  output logic [2*W-1:0]   nmag,
  output logic [W-1:0]     dmag,
  output logic             qneg,
  output logic             rneg,
  output logic             pre_ovf,
  output logic             zdiv
);

  function automatic logic [W-1:0] abs_w(input logic [W-1:0] x, input logic neg);
    return neg ? (~x + W'(1)) : x;
  endfunction

  function automatic logic [2*W-1:0] abs_2w(input logic [2*W-1:0] x, input logic neg);
    return neg ? (~x + (2*W)'(1)) : x;
  endfunction

  logic          use_wide;
  logic          sa, sb;
  logic [W-1:0]  amag_s;
  logic [2*W-1:0] amag_l;

  always_comb begin
    use_wide = mode.lng & ~mode.frac;
    sa       = mode.sgn & (use_wide ? dividend[2*W-1] : dividend[W-1]);
    sb       = mode.sgn & divisor[W-1];
    amag_s   = abs_w(dividend[W-1:0], sa);
    amag_l   = abs_2w(dividend, sa);
    dmag     = abs_w(divisor, sb);
    if (mode.frac)
      nmag = {1'b0, amag_s, {(W-1){1'b0}}};     // align so the quotient is Q15
    else if (use_wide)
      nmag = amag_l;
    else
      nmag = {{W{1'b0}}, amag_s};
    zdiv    = (divisor == '0);
    pre_ovf = mode.frac ? (amag_s >= dmag)
                        : ({1'b0, nmag[2*W-1:W+1]} >= dmag);
    qneg    = sa ^ sb;
    rneg    = sa;
  end

endmodule

// File: rtl/stepdiv_iter.sv
module stepdiv_iter #(
  parameter int W = 16
) (
  input  logic [W-1:0] prem,
  input  logic [W:0]   lo,
  input  logic [W-1:0] dmag,
  output logic [W-1:0] prem_n,
  output logic [W:0]   lo_n
);

  // one shift-compare-subtract: bring in the next dividend bit,
  // subtract when it fits, shift the quotient bit into lo
  function automatic logic [W:0] trial(input logic [W-1:0] r, input logic b);
    return {r, b};
  endfunction

  logic [W:0]   t;
  logic         ge;
  logic [W-1:0] diff;

  always_comb begin
    t      = trial(prem, lo[W]);
    ge     = (t >= {1'b0, dmag});
    diff   = t[W-1:0] - dmag;
    prem_n = ge ? diff : t[W-1:0];
    lo_n   = {lo[W-1:0], ge};
  end

endmodule

// File: rtl/stepdiv_fix.sv
module stepdiv_fix #(
  parameter int W = 16
) (
  input  logic [W:0]   qmag,
  input  logic [W-1:0] rmag,
  input  logic         qneg,
  input  logic         rneg,
  input  logic         sgn,
  input  logic         frac,
  input  logic         pre_ovf,
  output logic [W-1:0] qout,
  output logic [W-1:0] rout,
  output logic         range_ovf
);

  localparam logic [W:0] HALF = (W+1)'(1) << (W-1);

  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] x, input logic neg);
    return neg ? (~x + W'(1)) : x;
  endfunction

  logic [W:0] lim;

  always_comb begin
    if (sgn | frac)
      lim = qneg ? HALF : (HALF - (W+1)'(1));
    else
      lim = {1'b0, {W{1'b1}}};
    range_ovf = pre_ovf | (qmag > lim);
    qout      = apply_sign(qmag[W-1:0], qneg);
    rout      = apply_sign(rmag, rneg);
  end

endmodule

// File: rtl/stepdiv.sv
module stepdiv
  import stepdiv_pkg::*;
#(
  parameter  int W     = 16,
  localparam int NSTEP = W + 1,
  localparam int LAST  = W + 2,
  localparam int CW    = $clog2(LAST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            is_long,
  input  logic            is_signed,
  input  logic            is_frac,
  input  logic [2*W-1:0]  dividend,
  input  logic [W-1:0]    divisor,
  output logic [W-1:0]    quotient,
  output logic [W-1:0]    remainder,
  output logic [CW-1:0]   stage,
  output logic            busy,
  output logic            done,
  output logic            ovf,
  output logic            dz
);

  // architecturally visible state
  logic [CW-1:0] stage_q;
  logic [W-1:0]  prem_q;
  logic [W:0]    lo_q;
  logic [W-1:0]  dmag_q;
  logic          qneg_q, rneg_q, povf_q, zdiv_q, sgn_q, frac_q;
  logic [W-1:0]  quo_q, rem_q;
  logic          ovf_q, dz_q, done_q;

  // named events for the checker
  phase_t ph;
  logic   ld_evt, it_evt, fin_evt;

  always_comb begin
    if (stage_q == '0)              ph = PH_LOAD;
    else if (stage_q == CW'(LAST))  ph = PH_FIX;
    else                            ph = PH_ITER;
  end

  assign ld_evt  = step & (ph == PH_LOAD);
  assign it_evt  = step & (ph == PH_ITER);
  assign fin_evt = step & (ph == PH_FIX);

  dmode_t         mode_in;
  logic [2*W-1:0] nmag;
  logic [W-1:0]   dmag;
  logic           qneg, rneg, pre_ovf, zdiv;

  assign mode_in = '{lng: is_long, sgn: is_signed, frac: is_frac};

  stepdiv_prep #(.W(W)) u_prep (
    .mode(mode_in), .dividend(dividend), .divisor(divisor),
    .nmag(nmag), .dmag(dmag), .qneg(qneg), .rneg(rneg),
    .pre_ovf(pre_ovf), .zdiv(zdiv)
  );

  logic [W-1:0] prem_n;
  logic [W:0]   lo_n;

  stepdiv_iter #(.W(W)) u_iter (
    .prem(prem_q), .lo(lo_q), .dmag(dmag_q),
    .prem_n(prem_n), .lo_n(lo_n)
  );

  logic [W-1:0] qout, rout;
  logic         range_ovf;

  stepdiv_fix #(.W(W)) u_fix (
    .qmag(lo_q), .rmag(prem_q), .qneg(qneg_q), .rneg(rneg_q),
    .sgn(sgn_q), .frac(frac_q), .pre_ovf(povf_q),
    .qout(qout), .rout(rout), .range_ovf(range_ovf)
  );

  logic err_fin;
  assign err_fin = zdiv_q | range_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prem_q  <= '0;
      lo_q    <= '0;
      dmag_q  <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      povf_q  <= 1'b0;
      zdiv_q  <= 1'b0;
      sgn_q   <= 1'b0;
      frac_q  <= 1'b0;
      quo_q   <= '0;
      rem_q   <= '0;
      ovf_q   <= 1'b0;
      dz_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (ld_evt) begin
      prem_q  <= {1'b0, nmag[2*W-1:W+1]};
      lo_q    <= nmag[W:0];
      dmag_q  <= dmag;
      qneg_q  <= qneg;
      rneg_q  <= rneg;
      povf_q  <= pre_ovf;
      zdiv_q  <= zdiv;
      sgn_q   <= is_signed;
      frac_q  <= is_frac;
      done_q  <= 1'b0;
      stage_q <= CW'(1);
    end else if (it_evt) begin
      prem_q  <= prem_n;
      lo_q    <= lo_n;
      stage_q <= stage_q + CW'(1);
    end else if (fin_evt) begin
      stage_q <= '0;
      done_q  <= 1'b1;
      dz_q    <= zdiv_q;
      ovf_q   <= range_ovf & ~zdiv_q;
      if (!err_fin) begin
        quo_q <= qout;
        rem_q <= rout;
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign stage     = stage_q;
  assign busy      = (stage_q != '0);
  assign done      = done_q;
  assign ovf       = ovf_q;
  assign dz        = dz_q;

endmodule

// File: rtl/stepdiv_sva.sv
module stepdiv_sva #(
  parameter int W    = 16,
  parameter int CW   = 5,
  parameter int LAST = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [CW-1:0] stage,
  input logic          done,
  input logic          ovf,
  input logic          dz,
  input logic [W-1:0]  quotient,
  input logic [W-1:0]  remainder,
  input logic          fin_evt,
  input logic          sgn_q,
  input logic          rneg_q,
  input logic [W-1:0]  dmag_q
);

  logic [W-1:0] rem_abs;
  assign rem_abs = rneg_q ? (~remainder + W'(1)) : remainder;

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(stage) && $stable(quotient) && $stable(remainder) &&
               $stable(done) && $stable(ovf) && $stable(dz)));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stage != CW'(LAST)) |=> (stage == CW'($past(stage) + 1'b1)));

  a_r2_wrap_done: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (stage == '0 && done));

  a_r10_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stage == '0) |=> !done);

  a_r10_flags_final_only: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_evt |=> ($stable(ovf) && $stable(dz)));

  a_r9_error_keeps_results: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (!(ovf || dz) || ($stable(quotient) && $stable(remainder))));

  a_r9_dz_excludes_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    dz |-> !ovf);

  a_r4_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf && !dz && sgn_q && remainder != '0) |-> (remainder[W-1] == rneg_q));

  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf && !dz) |-> (rem_abs < dmag_q));

endmodule

bind stepdiv stepdiv_sva #(.W(W), .CW(CW), .LAST(LAST)) u_sva (
  .clk(clk), .rst_n(rst_n), .step(step), .stage(stage), .done(done),
  .ovf(ovf), .dz(dz), .quotient(quotient), .remainder(remainder),
  .fin_evt(fin_evt), .sgn_q(sgn_q), .rneg_q(rneg_q), .dmag_q(dmag_q)
);

// File: tb/stepdiv_test.sv
`timescale 1ns/1ps
module stepdiv_test;
  localparam int W = 16;
  localparam int CW = 5;
  localparam int STEPS = 19;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, step, is_long, is_signed, is_frac;
  logic [2*W-1:0] dividend;
  logic [W-1:0] divisor, quotient, remainder;
  logic [CW-1:0] stage;
  logic busy, done, ovf, dz;

  stepdiv uut (
    .clk(clk), .rst_n(rst_n), .step(step), .is_long(is_long),
    .is_signed(is_signed), .is_frac(is_frac), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .stage(stage), .busy(busy), .done(done), .ovf(ovf), .dz(dz)
  );

  int n_run = 0;
  int n_bad = 0;
  bit ended = 0;
  logic [W-1:0] last_q = '0, last_r = '0;
  logic last_ovf = 1'b0, last_dz = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint labs(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic run_div(input logic [31:0] a, input logic [15:0] b,
                         input bit lng, input bit sgn, input bit frc,
                         input int maxgap, input bit scramble);
    longint A, B, Q, R;
    bit edz, eovf;
    logic [W-1:0] eq, er;
    string tag;
    Q = 0; R = 0;
    if (frc || !lng) begin
      A = sgn ? longint'($signed(a[15:0])) : longint'(a[15:0]);
    end else begin
      A = sgn ? longint'($signed(a)) : longint'(a);
    end
    B = sgn ? longint'($signed(b)) : longint'(b);
    edz = (B == 0);
    eovf = 0;
    if (!edz) begin
      if (frc) begin
        eovf = labs(A) >= labs(B);
        Q = (A * 32768) / B;
        R = (A * 32768) % B;
      end else begin
        Q = A / B;
        R = A % B;
        eovf = sgn ? (Q < -32768 || Q > 32767) : (Q > 65535);
      end
    end
    eq = (edz || eovf) ? last_q : Q[15:0];
    er = (edz || eovf) ? last_r : R[15:0];
    if (edz)       tag = "R9";
    else if (eovf) tag = frc ? "R7" : "R8";
    else           tag = frc ? "R6" : (sgn ? "R4" : "R5");
    if (scramble) tag = {tag, ",R1"};

    @(negedge clk);
    dividend = a; divisor = b; is_long = lng; is_signed = sgn; is_frac = frc;
    step = 1'b1;
    for (int k = 0; k < STEPS; k++) begin
      @(negedge clk);
      chk(stage == CW'((k + 1) % STEPS), "R2", "stage", stage, (k + 1) % STEPS);
      if (k == 0) begin
        chk(done == 1'b0, "R10", "done after load", done, 0);
        chk(ovf == last_ovf && dz == last_dz, "R10", "flags after load",
            {ovf, dz}, {last_ovf, last_dz});
        if (scramble) begin
          dividend = $urandom; divisor = $urandom;
          is_long = ~lng; is_signed = ~sgn; is_frac = ~frc;
        end
      end
      if (k < STEPS - 1) begin
        int gap;
        gap = (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0;
        if (gap > 0) begin
          logic [CW-1:0] st;
          st = stage;
          step = 1'b0;
          repeat (gap) @(negedge clk);
          chk(stage == st && busy && !done, "R3", "hold during gap", stage, st);
          step = 1'b1;
        end
      end else begin
        step = 1'b0;
      end
    end
    chk(done && !busy, "R2", "done/busy at end", {done, busy}, 2'b10);
    chk(quotient == eq, tag, "quotient", quotient, eq);
    chk(remainder == er, tag, "remainder", remainder, er);
    chk(ovf == (eovf && !edz), tag, "ovf", ovf, eovf && !edz);
    chk(dz == edz, tag, "dz", dz, edz);
    last_q = quotient; last_r = remainder; last_ovf = ovf; last_dz = dz;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_run++; n_bad++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 200000, 0);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; step = 1'b0; is_long = 1'b0; is_signed = 1'b0; is_frac = 1'b0;
    dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(quotient == 0 && remainder == 0, "R10", "reset results", {quotient, remainder}, 0);
    chk(stage == 0 && !busy && !done && !ovf && !dz, "R10", "reset status",
        {stage, busy, done, ovf, dz}, 0);

    // signed integer, all sign combinations
    run_div(32'd100, 16'd7, 1, 1, 0, 0, 0);
    run_div(-32'sd100, 16'd7, 1, 1, 0, 0, 0);
    run_div(32'd100, -16'sd7, 0, 1, 0, 0, 0);
    run_div(32'h0000_FF9C, 16'hFFF9, 0, 1, 0, 2, 0);
    run_div(32'h8000_0000, 16'hFFFF, 1, 1, 0, 0, 0);   // overflow R8
    run_div(32'h0000_8000, 16'hFFFF, 0, 1, 0, 1, 0);   // overflow R8
    run_div(32'h7FFF_0000, 16'h7FFF, 1, 1, 0, 0, 0);   // overflow R8
    run_div(32'hFFFF_8000, 16'h0001, 1, 1, 0, 0, 0);   // -32768 fits
    // unsigned integer
    run_div(32'h0000_FFFF, 16'h0001, 0, 0, 0, 0, 0);
    run_div(32'hFFFE_0001, 16'hFFFF, 1, 0, 0, 3, 0);
    run_div(32'hFFFF_0000, 16'hFFFF, 1, 0, 0, 0, 0);   // overflow R8
    run_div(32'h1234_5678, 16'h0000, 1, 0, 0, 0, 0);   // zero divisor R9
    run_div(32'd5, 16'd0, 0, 1, 1, 0, 0);               // zero divisor R9
    // fractional Q15
    run_div(32'h0000_4000, 16'h7FFF, 0, 1, 1, 0, 0);
    run_div(32'h0000_C000, 16'h6000, 1, 1, 1, 0, 0);    // is_long ignored R6
    run_div(32'h0000_8000, 16'h8000, 0, 1, 1, 0, 0);    // overflow R7
    run_div(32'h0000_2000, 16'hC000, 0, 1, 1, 2, 0);
    run_div(32'h0000_9000, 16'hF000, 0, 0, 1, 0, 0);    // unsigned frac
    run_div(32'h0000_7000, 16'h7000, 0, 0, 1, 0, 0);    // overflow R7
    // operands changed after load
    run_div(32'd1000, 16'd33, 1, 1, 0, 1, 1);
    run_div(32'h0000_1000, 16'h3000, 0, 1, 1, 0, 1);

    for (int i = 0; i < 1200; i++) begin
      logic [31:0] a;
      logic [15:0] b;
      a = $urandom;
      if ($urandom % 2) a = a >> ($urandom % 32);
      b = 16'($urandom);
      case ($urandom % 4)
        0: b = b % 16'd9;
        1: b = b >> ($urandom % 16);
        default: ;
      endcase
      run_div(a, b, 1'($urandom), 1'($urandom), 1'($urandom),
              int'($urandom % 3), 1'($urandom));
    end

    summary();
  end
endmodule